// File: doc/BRIEF.md
# Cache-Inhibit and Data-Strobe Decoder

This block bridges a 32-bit processor bus that sizes its transfers on the fly to a 16-bit asynchronous memory and peripheral bus. For every bus cycle it makes a fresh decision on whether the access may be held in the processor's data cache. That decision is driven out as an active-low cache-inhibit. The block also produces the upper and lower byte strobes for the 16-bit side, and it answers with an acknowledge that reports a 16-bit port.

The cache must be inhibited when a data-space cycle lands in one of two places. The first is the low memory that other bus masters reach by DMA, because its contents can change behind the cache. The second is the peripheral register window. Everywhere else is cacheable.

A cacheable region must always hand back a full 16-bit word on reads, so on such reads both strobes fire whatever size was asked for. Inhibited cycles and all writes get strobes that match the requested size and alignment exactly, so a byte write never disturbs its neighbour.

Top module: `cinh_strobe_ctl`

## Requirements
- R1: A data-space cycle (function code 3'b001 or 3'b101) whose address is in 0x00000000..0x001FFFFF drives cache-inhibit low (cinh_n_o = 0).
- R2: A data-space cycle whose address is in 0x00A00000..0x00DFFFFF drives cinh_n_o = 0.
- R3: Cycles with any other function code never assert cache-inhibit. Data-space cycles at any address outside both windows, including 0x00200000, 0x009FFFFF and 0x00E00000, leave cinh_n_o = 1.
- R4: Cache-inhibit is decided again on each bus cycle from that cycle's own address and function code. Nothing carries over from the previous cycle.
- R5: A read (rw_i = 1) that is not inhibited asserts both strobes (ustb_n_o = 0, lstb_n_o = 0) for every size code and every value of address bit 0.
- R6: Inhibited cycles and all writes use size-exact strobes. The size code is 2'b01 = byte, 2'b10 = word, 2'b11 = three bytes, 2'b00 = long. A byte with address bit 0 = 0 asserts only ustb_n_o. A byte with address bit 0 = 1 asserts only lstb_n_o. Every other size asserts both strobes.
- R7: Outputs follow the address strobe (as_n_i, active low) with one register stage. They take their cycle values at the first rising edge that samples as_n_i = 0. They all return high at the first rising edge that samples as_n_i = 1.
- R8: The port-size acknowledge ack_n_o goes low WAIT_STATES rising edges after the strobes first assert. It stays low until the address strobe is released.
- R9: While reset is applied, all four outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Byte address of the current cycle |
| fc_i | input | 3 | Function code (address space) |
| siz_i | input | 2 | Requested transfer size code |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_n_i | input | 1 | Address strobe, active low |
| cinh_n_o | output | 1 | Cache-inhibit for this cycle, active low |
| ustb_n_o | output | 1 | Upper byte strobe, active low |
| lstb_n_o | output | 1 | Lower byte strobe, active low |
| ack_n_o | output | 1 | 16-bit port-size acknowledge, active low |

## Verification
The bench builds the block with its default region bounds and WAIT_STATES = 2. With two wait states the acknowledge lags the strobes by a visible margin. Bus cycles held for one to four clocks then cover both the case where the strobe is released before the acknowledge can arrive and the case where the acknowledge is held for several clocks. The sweep puts even and odd addresses on each side of all three region edges, and crosses them with all eight function codes, all four size codes and both directions.

// File: rtl/cinh_pkg.sv
package cinh_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    SZ_LONG  = 2'b00,
    SZ_BYTE  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_TRIPL = 2'b11
  } xfer_size_e;

  localparam logic [2:0] FC_USER_DATA = 3'b001;
  localparam logic [2:0] FC_SUPV_DATA = 3'b101;

  localparam logic [ADDR_W-1:0] DEF_SHARED_LO = 32'h0000_0000;
  localparam logic [ADDR_W-1:0] DEF_SHARED_HI = 32'h001F_FFFF;
  localparam logic [ADDR_W-1:0] DEF_PERIPH_LO = 32'h00A0_0000;
  localparam logic [ADDR_W-1:0] DEF_PERIPH_HI = 32'h00DF_FFFF;

  typedef struct packed {
    logic inhibit;
    logic upper;
    logic lower;
  } lane_ctl_t;
endpackage

// File: rtl/cinh_region_dec.sv
module cinh_region_dec #(
  parameter int AW   = 32,
  parameter int NREG = 2,
  parameter logic [NREG*AW-1:0] LO_BOUNDS = '0,
  parameter logic [NREG*AW-1:0] HI_BOUNDS = '1
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    fc,
  output logic          inhibit
);
  import cinh_pkg::*;

  logic [NREG-1:0] hit;
  logic            data_space;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_win
      localparam logic [AW-1:0] LO = LO_BOUNDS[g*AW +: AW];
      localparam logic [AW-1:0] HI = HI_BOUNDS[g*AW +: AW];
      always_comb begin
        hit[g] = (addr >= LO) && (addr <= HI);
      end
    end
  endgenerate

  always_comb begin
    data_space = (fc == FC_USER_DATA) || (fc == FC_SUPV_DATA);
    inhibit    = data_space && (|hit);
  end

  // R3: non-data address spaces must never be inhibited
  always_comb begin
    a_r3_nondata_free : assert (!(inhibit && !(fc[1:0] == 2'b01)))
      else $error("inhibit raised outside data space");
  end
endmodule

// File: rtl/cinh_strobe_gen.sv
module cinh_strobe_gen (
  input  logic [1:0] siz,
  input  logic       a0,
  input  logic       rd,
  input  logic       inhibit,
  output logic       upper,
  output logic       lower
);
  import cinh_pkg::*;

  logic full_width;
  logic is_byte;

  always_comb begin
    full_width = rd && !inhibit;
    is_byte    = (siz == SZ_BYTE);
    if (full_width || !is_byte) begin
      upper = 1'b1;
      lower = 1'b1;
    end else begin
      upper = !a0;
      lower = a0;
    end
  end

  // R6: a sized byte lane selects exactly one strobe
  always_comb begin
    if (is_byte && !full_width) begin
      a_r6_byte_one_lane : assert ($countones({upper, lower}) == 1)
        else $error("byte access did not select a single lane");
    end
  end
endmodule

// File: rtl/cinh_ack_seq.sv
module cinh_ack_seq #(
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_act,
  output logic active,
  output logic ack
);
  localparam int CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] WLIM = CNT_W'(WAIT_STATES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             ack_q, ack_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = 1'b0;
    ack_d = 1'b0;
    if (as_act) begin
      act_d = 1'b1;
      if (!act_q) begin
        cnt_d = '0;
      end else if (cnt_q != WLIM) begin
        cnt_d = cnt_q + 1'b1;
      end
      ack_d = (cnt_d >= WLIM);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      ack_q <= ack_d;
    end
  end

  assign active = act_q;
  assign ack    = ack_q;

  // R8: once given, the acknowledge holds while the strobe stays active
  a_r8_ack_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && as_act) |=> ack_q)
    else $error("acknowledge dropped mid-cycle");

  // R8: the acknowledge never precedes the start of a cycle
  a_r8_ack_needs_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> act_q)
    else $error("acknowledge outside an active cycle");
endmodule

// File: rtl/cinh_strobe_ctl.sv
module cinh_strobe_ctl #(
  parameter int ADDR_W = cinh_pkg::ADDR_W,
  parameter int WAIT_STATES = 2,
  parameter logic [ADDR_W-1:0] SHARED_LO = cinh_pkg::DEF_SHARED_LO,
  parameter logic [ADDR_W-1:0] SHARED_HI = cinh_pkg::DEF_SHARED_HI,
  parameter logic [ADDR_W-1:0] PERIPH_LO = cinh_pkg::DEF_PERIPH_LO,
  parameter logic [ADDR_W-1:0] PERIPH_HI = cinh_pkg::DEF_PERIPH_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic [1:0]        siz_i,
  input  logic              rw_i,
  input  logic              as_n_i,
  output logic              cinh_n_o,
  output logic              ustb_n_o,
  output logic              lstb_n_o,
  output logic              ack_n_o
);
  import cinh_pkg::*;

  localparam int NREG = 2;
  localparam logic [NREG*ADDR_W-1:0] LO_SET = {PERIPH_LO, SHARED_LO};
  localparam logic [NREG*ADDR_W-1:0] HI_SET = {PERIPH_HI, SHARED_HI};

  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ok = rst_sync_q[1];

  logic      as_act;
  logic      inhibit;
  logic      up_c, lo_c;
  logic      seq_active;
  logic      seq_ack;
  lane_ctl_t ctl_d, ctl_q;

  assign as_act = !as_n_i;

  cinh_region_dec #(
    .AW(ADDR_W), .NREG(NREG), .LO_BOUNDS(LO_SET), .HI_BOUNDS(HI_SET)
  ) u_region (
    .addr(addr_i), .fc(fc_i), .inhibit(inhibit)
  );

  cinh_strobe_gen u_strobe (
    .siz(siz_i), .a0(addr_i[0]), .rd(rw_i), .inhibit(inhibit),
    .upper(up_c), .lower(lo_c)
  );

  cinh_ack_seq #(.WAIT_STATES(WAIT_STATES)) u_ack (
    .clk(clk), .rst_n(rst_ok), .as_act(as_act),
    .active(seq_active), .ack(seq_ack)
  );

  always_comb begin
    ctl_d = '0;
    if (as_act) begin
      ctl_d.inhibit = inhibit;
      ctl_d.upper   = up_c;
      ctl_d.lower   = lo_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign cinh_n_o = !ctl_q.inhibit;
  assign ustb_n_o = !ctl_q.upper;
  assign lstb_n_o = !ctl_q.lower;
  assign ack_n_o  = !seq_ack;

  // R7: one edge after the strobe is released, every output is idle
  a_r7_release : assert property (@(posedge clk) disable iff (!rst_ok)
    $past(as_n_i) |-> (cinh_n_o && ustb_n_o && lstb_n_o && ack_n_o))
    else $error("outputs not released after address strobe");

  // R3: inhibit only ever follows a data-space cycle
  a_r3_inhibit_data_only : assert property (@(posedge clk) disable iff (!rst_ok)
    !cinh_n_o |-> ($past(fc_i) == FC_USER_DATA || $past(fc_i) == FC_SUPV_DATA))
    else $error("inhibit after non-data cycle");

  // R5: cacheable reads come back full width
  a_r5_full_width_read : assert property (@(posedge clk) disable iff (!rst_ok)
    (!$past(as_n_i) && $past(rw_i) && cinh_n_o) |-> (!ustb_n_o && !lstb_n_o))
    else $error("cacheable read not full width");

  // R8: acknowledge only accompanies an active strobe
  a_r8_ack_with_strobe : assert property (@(posedge clk) disable iff (!rst_ok)
    !ack_n_o |-> ((!ustb_n_o || !lstb_n_o) && seq_active))
    else $error("acknowledge without strobe");
endmodule

// File: tb/cinh_strobe_ctl_tb_top.sv
module cinh_strobe_ctl_tb_top;
  localparam int WAITS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  fc = '0;
  logic [1:0]  siz = '0;
  logic        rw = 1'b1;
  logic        as_n = 1'b1;
  logic        cinh_n, ustb_n, lstb_n, ack_n;

  always #4 clk = ~clk;

  cinh_strobe_ctl #(.WAIT_STATES(WAITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .fc_i(fc), .siz_i(siz),
    .rw_i(rw), .as_n_i(as_n), .cinh_n_o(cinh_n), .ustb_n_o(ustb_n),
    .lstb_n_o(lstb_n), .ack_n_o(ack_n)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit    m_act = 0;
  int    m_k = 0;
  bit    e_ci = 0, e_u = 0, e_l = 0, e_ack = 0;
  string t_ci = "R9", t_st = "R9", t_ack = "R9";

  always @(posedge clk) begin
    bit dsp, shared, periph, inh;
    if (!rst_n) begin
      m_act = 0; m_k = 0;
      e_ci = 0; e_u = 0; e_l = 0; e_ack = 0;
      t_ci = "R9"; t_st = "R9"; t_ack = "R9";
    end else if (as_n) begin
      m_act = 0; m_k = 0;
      e_ci = 0; e_u = 0; e_l = 0; e_ack = 0;
      t_ci = "R7"; t_st = "R7"; t_ack = "R7";
    end else begin
      if (!m_act) begin m_act = 1; m_k = 0; end
      else m_k = m_k + 1;
      dsp    = (fc == 3'd1) || (fc == 3'd5);
      shared = (addr <= 32'h001F_FFFF);
      periph = (addr >= 32'h00A0_0000) && (addr <= 32'h00DF_FFFF);
      inh    = dsp && (shared || periph);
      e_ci   = inh;
      t_ci   = !inh ? "R3/R4" : (shared ? "R1" : "R2");
      if (rw && !inh) begin
        e_u = 1; e_l = 1; t_st = "R5";
      end else if (siz == 2'b01) begin
        e_u = !addr[0]; e_l = addr[0]; t_st = "R6";
      end else begin
        e_u = 1; e_l = 1; t_st = "R6";
      end
      e_ack = (m_k >= WAITS);
      t_ack = "R8";
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b addr=%h fc=%0d siz=%0d rw=%b t=%0t",
               tag, what, act, exp, addr, fc, siz, rw, $time);
    end
  endtask

  // compare every clock, away from the active edge (outputs are low-true)
  always @(negedge clk) begin
    if (!done) begin
      chk(t_ci,  "cinh_n", cinh_n, !e_ci);
      chk(t_st,  "ustb_n", ustb_n, !e_u);
      chk(t_st,  "lstb_n", lstb_n, !e_l);
      chk(t_ack, "ack_n",  ack_n,  !e_ack);
    end
  end

  task automatic bus_cycle(input logic [31:0] a, input logic [2:0] f,
                           input logic [1:0] s, input logic r, input int hold);
    @(negedge clk);
    addr = a; fc = f; siz = s; rw = r; as_n = 1'b0;
    for (int h = 1; h < hold; h++) @(negedge clk);
    @(negedge clk);
    as_n = 1'b1;
  endtask

  logic [31:0] bases [8] = '{32'h001F_FFFE, 32'h0020_0000, 32'h009F_FFFE, 32'h00A0_0000,
                            32'h00DF_FFFE, 32'h00E0_0000, 32'h0000_0000, 32'hFFFF_FFFE};

  initial begin
    // R9: reset state is checked by the per-clock comparator while rst_n is low
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 8; b++)
      for (int odd = 0; odd < 2; odd++)
        for (int f = 0; f < 8; f++)
          for (int s = 0; s < 4; s++)
            for (int r = 0; r < 2; r++)
              bus_cycle(bases[b] | 32'(odd), 3'(f), 2'(s), r[0], 1 + ((b + f + s + r) % 4));
    // R4: back-to-back cycles alternating inhibited and cacheable regions
    for (int i = 0; i < 8; i++) begin
      bus_cycle(32'h0010_0000, 3'd5, 2'b01, 1'b1, 3);
      bus_cycle(32'h0040_0001, 3'd5, 2'b01, 1'b1, 3);
    end
    // R9: reapply reset in the middle of a held cycle
    @(negedge clk);
    addr = 32'h00B0_0000; fc = 3'd1; siz = 2'b01; rw = 1'b0; as_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    as_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule